// File: doc/BRIEF.md
# Selectable Clock Output Router

This block drives three independent clock outputs, each taking its clock from a shared set of candidate sources chosen by a 4-bit select field. The candidates are the undivided high-frequency source clock, an export clock divided down from it by a programmable factor, the raw outputs of four oscillators, the qualified outputs of six oscillators, and the qualified crystal clock divided by two. A qualified clock stays low until its oscillator reports ready, so startup glitches and runt pulses never reach a consumer.

Each selected clock feeds two destinations. The pin path passes the clock only while that output's route-enable bit is set. The event-fabric path always carries the selected clock, whatever the route setting. Source changes go through a glitch-free switch: the old clock is stopped while low before the new one is let through while low. The route gate also changes state only while the selected clock is low.

Top module: `clkout_router`

## Requirements
- R1: Select code 0, and every code above 13, holds both outputs of that channel low. The select of output k is `src_sel[4k+3:4k]`.
- R2: Code 1 selects the high-frequency source clock `hf_src_clk`. Code 2 selects the export clock.
- R3: The export clock divides `hf_src_clk` by f = `exp_div` + 1 and is high for floor(f/2) of every f source cycles. When f = 1 it is `hf_src_clk` itself, with 50% duty.
- R4: Codes 3 to 6 select the raw clocks `osc_clk[0]` to `osc_clk[3]`. These run whatever the ready flags are.
- R5: Codes 7 to 12 select the qualified clocks of `osc_clk[0]` to `osc_clk[5]`. A qualified clock stays low while `osc_rdy` of that oscillator is low, and runs at the oscillator rate once the flag is high.
- R6: Code 13 selects the qualified crystal clock (`osc_clk[3]`) divided by two. The divider is held in reset and its output stays low while that crystal is not ready.
- R7: `pin_clk[k]` carries the selected clock when `route_en[k]` is 1 and is held low when it is 0. It is never high while `fabric_clk[k]` is low.
- R8: `fabric_clk[k]` carries the selected clock whatever the value of `route_en[k]`.
- R9: Inside one channel, at most one source is let through at any time, so a select change never produces a merged or shortened pulse.
- R10: While `rst_n` is low, all pin and fabric outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hf_src_clk | input | 1 | Undivided high-frequency source clock; also drives the export divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 6 | Oscillator clocks; the crystal is index 3 and indices 0 to 3 also have raw taps |
| osc_rdy | input | 6 | Per-oscillator ready flags; these qualify the clocks |
| exp_div | input | 4 | Export divide factor minus one |
| src_sel | input | 12 | Three 4-bit source select codes; output k uses bits 4k+3:4k |
| route_en | input | 3 | Per-output pin route enable |
| pin_clk | output | 3 | Route-gated clock outputs toward the pins |
| fabric_clk | output | 3 | Ungated clock outputs toward the event fabric |

## Verification
Each result appears only after a chain of registers clocked by the clocks themselves. After a select change, the fabric output follows after two falling edges of the old source and then two falling edges of the new one. The pin gate needs two more falling edges of the selected clock. A new ready flag reaches the qualified clock after two falling edges of its oscillator. The slowest of these chains lasts about 300 time units, so after every configuration change the bench waits 600 units before opening a 2000-unit window. In that window it counts rising edges and compares the count with the window length divided by the expected period, allowing one edge either way for phase. For duty checks it samples the export clock at odd time units, which never coincide with a source clock edge.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  // select field and source population
  localparam int SEL_W     = 4;
  localparam int NUM_OSC   = 6;
  localparam int NUM_RAW   = 4;
  localparam int XTAL_IDX  = 3;
  localparam int NUM_OUT   = 3;
  localparam int DIV_W     = 4;

  // code map: slot index equals the select code
  localparam int CODE_OFF   = 0;
  localparam int CODE_SRC   = 1;
  localparam int CODE_EXP   = 2;
  localparam int CODE_RAW0  = 3;
  localparam int CODE_QUAL0 = CODE_RAW0 + NUM_RAW;
  localparam int CODE_HALF  = CODE_QUAL0 + NUM_OSC;
  localparam int NUM_SLOT   = CODE_HALF + 1;
endpackage

// File: rtl/clk_prescaler.sv
module clk_prescaler #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  output logic             exp_clk
);
  localparam int CW = DIV_W + 1;

  // reset asserted asynchronously, released on clk
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  logic [DIV_W-1:0] cnt_q, cnt_nxt;
  logic [CW-1:0]    high_len;
  logic             div_q, div_nxt;
  logic             bypass, cnt_en;

  always_comb begin
    bypass   = (div_sel == '0);
    cnt_en   = ~bypass;
    high_len = (CW'(div_sel) + CW'(1)) >> 1;
    if (cnt_q >= div_sel) cnt_nxt = '0;
    else                  cnt_nxt = cnt_q + 1'b1;
    div_nxt  = (CW'(cnt_nxt) < high_len);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
      div_q <= div_nxt;
    end
  end

  assign exp_clk = bypass ? clk : div_q;

  // R3
  prescale_wrap_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cnt_en && cnt_q >= div_sel) |=> (cnt_q == '0));
endmodule

// File: rtl/osc_qualifier.sv
module osc_qualifier #(
  parameter int NUM_OSC  = 6,
  parameter int XTAL_IDX = 3
) (
  input  logic               rst_n,
  input  logic [NUM_OSC-1:0] osc_clk,
  input  logic [NUM_OSC-1:0] osc_rdy,
  output logic [NUM_OSC-1:0] qual_clk,
  output logic               half_clk
);
  logic [NUM_OSC-1:0] gate_vec;

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
    logic rdy_s1_q, gate_q;
    // ready is resampled on the falling edge so the gate moves while low
    always_ff @(negedge osc_clk[g] or negedge rst_n) begin
      if (!rst_n) begin
        rdy_s1_q <= 1'b0;
        gate_q   <= 1'b0;
      end else begin
        rdy_s1_q <= osc_rdy[g];
        gate_q   <= rdy_s1_q;
      end
    end
    assign gate_vec[g] = gate_q;
    assign qual_clk[g] = osc_clk[g] & gate_q;

    // R5
    qual_hold_chk: assert property (@(negedge osc_clk[g]) disable iff (!rst_n)
      !rdy_s1_q |=> !gate_q);
  end

  // divide-by-two of the qualified crystal, reset while not ready
  logic half_rst_n, half_q, half_nxt;
  assign half_rst_n = rst_n & gate_vec[XTAL_IDX];

  always_comb half_nxt = ~half_q;

  always_ff @(posedge qual_clk[XTAL_IDX] or negedge half_rst_n) begin
    if (!half_rst_n) half_q <= 1'b0;
    else             half_q <= half_nxt;
  end

  assign half_clk = half_q;

  // R6
  half_toggle_chk: assert property (@(posedge qual_clk[XTAL_IDX]) disable iff (!half_rst_n)
    half_rst_n |=> (half_q != $past(half_q)));
endmodule

// File: rtl/clkout_channel.sv
module clkout_channel #(
  parameter int NUM_SLOT = 14,
  parameter int SEL_W    = 4
) (
  input  logic                rst_n,
  input  logic [NUM_SLOT-1:0] slot_clk,
  input  logic [SEL_W-1:0]    sel,
  input  logic                route_en,
  output logic                pin_clk,
  output logic                fabric_clk
);
  logic [NUM_SLOT-1:0] en_vec;
  assign en_vec[0] = 1'b0;

  for (genvar i = 1; i < NUM_SLOT; i++) begin : g_slot
    logic req, others_on, s1_q, s1_nxt, en_q;

    always_comb begin
      req       = (sel == SEL_W'(i));
      others_on = |(en_vec & ~(NUM_SLOT'(1) << i));
      s1_nxt    = req & ~others_on;
    end

    always_ff @(negedge slot_clk[i] or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        en_q <= 1'b0;
      end else begin
        s1_q <= s1_nxt;
        en_q <= s1_q;
      end
    end
    assign en_vec[i] = en_q;

    // R9
    one_src_chk: assert property (@(posedge slot_clk[i]) disable iff (!rst_n)
      $onehot0(en_vec));
  end

  assign fabric_clk = |(slot_clk & en_vec);

  // route gate moves only while the selected clock is low
  logic route_s1_q, route_q;
  always_ff @(negedge fabric_clk or negedge rst_n) begin
    if (!rst_n) begin
      route_s1_q <= 1'b0;
      route_q    <= 1'b0;
    end else begin
      route_s1_q <= route_en;
      route_q    <= route_s1_q;
    end
  end

  assign pin_clk = fabric_clk & route_q;
endmodule

// File: rtl/clkout_router.sv
module clkout_router
  import clkout_pkg::*;
#(
  parameter int P_NUM_OSC  = NUM_OSC,
  parameter int P_NUM_OUT  = NUM_OUT,
  parameter int P_DIV_W    = DIV_W
) (
  input  logic                       hf_src_clk,
  input  logic                       rst_n,
  input  logic [P_NUM_OSC-1:0]       osc_clk,
  input  logic [P_NUM_OSC-1:0]       osc_rdy,
  input  logic [P_DIV_W-1:0]         exp_div,
  input  logic [P_NUM_OUT*SEL_W-1:0] src_sel,
  input  logic [P_NUM_OUT-1:0]       route_en,
  output logic [P_NUM_OUT-1:0]       pin_clk,
  output logic [P_NUM_OUT-1:0]       fabric_clk
);
  logic                 exp_clk;
  logic [P_NUM_OSC-1:0] qual_clk;
  logic                 half_clk;
  logic [NUM_SLOT-1:0]  slot_clk;

  clk_prescaler #(.DIV_W(P_DIV_W)) i_prescaler (
    .clk     (hf_src_clk),
    .rst_n   (rst_n),
    .div_sel (exp_div),
    .exp_clk (exp_clk)
  );

  osc_qualifier #(.NUM_OSC(P_NUM_OSC), .XTAL_IDX(XTAL_IDX)) i_qualifier (
    .rst_n    (rst_n),
    .osc_clk  (osc_clk),
    .osc_rdy  (osc_rdy),
    .qual_clk (qual_clk),
    .half_clk (half_clk)
  );

  // source slots, indexed by select code
  assign slot_clk[CODE_OFF]  = 1'b0;
  assign slot_clk[CODE_SRC]  = hf_src_clk;
  assign slot_clk[CODE_EXP]  = exp_clk;
  assign slot_clk[CODE_HALF] = half_clk;
  for (genvar r = 0; r < NUM_RAW; r++) begin : g_raw
    assign slot_clk[CODE_RAW0+r] = osc_clk[r];
  end
  for (genvar q = 0; q < NUM_OSC; q++) begin : g_qual
    assign slot_clk[CODE_QUAL0+q] = qual_clk[q];
  end

  for (genvar k = 0; k < P_NUM_OUT; k++) begin : g_out
    clkout_channel #(.NUM_SLOT(NUM_SLOT), .SEL_W(SEL_W)) i_channel (
      .rst_n      (rst_n),
      .slot_clk   (slot_clk),
      .sel        (src_sel[k*SEL_W +: SEL_W]),
      .route_en   (route_en[k]),
      .pin_clk    (pin_clk[k]),
      .fabric_clk (fabric_clk[k])
    );

    // R7
    pin_within_fabric_chk: assert property (@(posedge hf_src_clk) disable iff (!rst_n)
      pin_clk[k] |-> fabric_clk[k]);
  end

  // R10
  always_comb begin
    if (!rst_n) reset_quiet_chk: assert ((pin_clk == '0) && (fabric_clk == '0));
  end
endmodule

// File: tb/test_clkout_router.sv
module test_clkout_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  osc = '0;
  logic [5:0]  rdy = '0;
  logic [3:0]  exp_div = 4'd3;
  logic [11:0] sel = '0;
  logic [2:0]  route = '0;
  logic [2:0]  pin, fab;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam int WIN    = 2000;
  localparam int SETTLE = 600;
  int half_per [6] = '{37, 29, 23, 13, 11, 17};

  always #4 clk = ~clk;
  always #37 osc[0] = ~osc[0];
  always #29 osc[1] = ~osc[1];
  always #23 osc[2] = ~osc[2];
  always #13 osc[3] = ~osc[3];
  always #11 osc[4] = ~osc[4];
  always #17 osc[5] = ~osc[5];

  clkout_router i_clkout_router (
    .hf_src_clk (clk),
    .rst_n      (rst_n),
    .osc_clk    (osc),
    .osc_rdy    (rdy),
    .exp_div    (exp_div),
    .src_sel    (sel),
    .route_en   (route),
    .pin_clk    (pin),
    .fabric_clk (fab)
  );

  int fe0 = 0, fe1 = 0, fe2 = 0, pe0 = 0, pe1 = 0, pe2 = 0;
  always @(posedge fab[0]) fe0 = fe0 + 1;
  always @(posedge fab[1]) fe1 = fe1 + 1;
  always @(posedge fab[2]) fe2 = fe2 + 1;
  always @(posedge pin[0]) pe0 = pe0 + 1;
  always @(posedge pin[1]) pe1 = pe1 + 1;
  always @(posedge pin[2]) pe2 = pe2 + 1;

  int fd [3];
  int pd [3];

  task automatic check(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic measure();
    int f0, f1, f2, p0, p1, p2;
    #SETTLE;
    f0 = fe0; f1 = fe1; f2 = fe2; p0 = pe0; p1 = pe1; p2 = pe2;
    #WIN;
    fd[0] = fe0 - f0; fd[1] = fe1 - f1; fd[2] = fe2 - f2;
    pd[0] = pe0 - p0; pd[1] = pe1 - p1; pd[2] = pe2 - p2;
  endtask

  // expected period for a code, all oscillators ready; 0 = held low
  function automatic int period_of(input int code, input int div);
    if (code == 1) return 8;
    if (code == 2) return 8 * (div + 1);
    if (code >= 3 && code <= 6) return 2 * half_per[code-3];
    if (code >= 7 && code <= 12) return 2 * half_per[code-7];
    if (code == 13) return 4 * half_per[3];
    return 0;
  endfunction

  function automatic string tag_of(input int code);
    if (code == 1 || code == 2) return "R2";
    if (code >= 3 && code <= 6) return "R4";
    if (code >= 7 && code <= 12) return "R5";
    if (code == 13) return "R6";
    return "R1";
  endfunction

  task automatic check_rate(input string tag, input int act, input int per);
    int e;
    e = (per == 0) ? 0 : WIN / per;
    check(tag, act, (e > 0) ? e - 1 : 0, (e > 0) ? e + 1 : 0);
  endtask

  task automatic duty(output int hi_cnt);
    hi_cnt = 0;
    @(posedge clk);
    #1;
    for (int n = 0; n < 1200; n++) begin
      if (fab[0]) hi_cnt++;
      #2;
    end
  endtask

  initial begin
    int hc;
    int c0, c1, c2;
    // reset state
    repeat (3) @(negedge clk);
    check("R10 pins low in reset", int'(pin), 0, 0);
    check("R10 fabric low in reset", int'(fab), 0, 0);
    @(negedge clk) rst_n = 1'b1;

    // code 0 everywhere
    measure();
    check_rate("R1 code0 out0", fd[0], 0);
    check_rate("R1 code0 out2", fd[2], 0);

    // qualification before ready
    @(negedge clk);
    sel = {4'd3, 4'd13, 4'd7};
    route = 3'b111;
    measure();
    check_rate("R5 not ready qual held low", fd[0], 0);
    check_rate("R6 not ready half held low", fd[1], 0);
    check_rate("R4 raw runs without ready", fd[2], 74);
    @(negedge clk) rdy = 6'h3f;
    measure();
    check_rate("R5 qual runs after ready", fd[0], 74);
    check_rate("R6 half runs after ready", fd[1], 52);

    // sweep every code over every output
    for (int code = 0; code < 16; code++) begin
      @(negedge clk);
      c0 = code; c1 = (code + 5) % 16; c2 = (code + 11) % 16;
      sel = {4'(c2), 4'(c1), 4'(c0)};
      route = code[0] ? 3'b010 : 3'b101;
      measure();
      check_rate({tag_of(c0), " sweep fabric out0"}, fd[0], period_of(c0, 3));
      check_rate({tag_of(c1), " sweep fabric out1"}, fd[1], period_of(c1, 3));
      check_rate({tag_of(c2), " sweep fabric out2"}, fd[2], period_of(c2, 3));
      for (int k = 0; k < 3; k++) begin
        int ck;
        ck = (k == 0) ? c0 : (k == 1) ? c1 : c2;
        if (route[k]) check_rate("R7 pin follows when routed", pd[k], period_of(ck, 3));
        else          check_rate("R7 pin low when unrouted", pd[k], 0);
        if (!route[k]) check_rate("R8 fabric ignores route", fd[k], period_of(ck, 3));
      end
    end

    // export factors and duty
    @(negedge clk);
    sel = {4'd0, 4'd0, 4'd2};
    route = 3'b001;
    exp_div = 4'd0;
    measure();
    check_rate("R3 factor 1 rate", fd[0], 8);
    duty(hc);
    check("R3 factor 1 duty", hc, 570, 630);
    @(negedge clk) exp_div = 4'd2;
    measure();
    check_rate("R3 factor 3 rate", fd[0], 24);
    duty(hc);
    check("R3 factor 3 duty", hc, 370, 430);
    @(negedge clk) exp_div = 4'd3;
    measure();
    check_rate("R3 factor 4 rate", fd[0], 32);
    duty(hc);
    check("R3 factor 4 duty", hc, 570, 630);
    // R9: clean switch from export to crystal half, rate stays exact
    @(negedge clk) sel = {4'd0, 4'd0, 4'd13};
    measure();
    check_rate("R9 switched source rate", fd[0], 52);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end
endmodule